// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a down-counter whose count width is set by a parameter. It counts at one of four tick rates, and all four rates come from a single base clock-enable. A fixed divide-by-`PRE_DIV` stage produces the fastest rate. A chain of divide-by-four steps produces the three slower rates. When the base enable pulses at `PRE_DIV` × 1024 Hz, the four select codes give 1024, 256, 64 and 16 Hz.

Software loads an initial value and runs the counter with four single-cycle strobes: start, pause, resume and stop. Pause and stop do different things. Pause freezes both the count and the prescaler phase, so that a later resume carries on where the counter left off. Stop returns the timer to idle and clears the count.

On expiry the counter either stops at zero or reloads the initial value and keeps running. Which one happens depends on the repeat input. Every expiry sets a sticky flag, and the interrupt output is that flag gated by an enable input.

Top module: `pscl_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `flag` is 0, `irq` is 0 and the timer is idle.
- R2: The select code `rate_sel` picks the tick period, counted in `base_ce` pulses: code 0 gives `PRE_DIV`, code 1 gives 4×`PRE_DIV`, code 2 gives 16×`PRE_DIV` and code 3 gives 64×`PRE_DIV`.
- R3: `start` loads `init_val` into `count` on the next clock edge and clears the prescaler. The first decrement comes one full tick period after that edge.
- R4: While the timer is running, each tick lowers `count` by exactly one.
- R5: `pause` while running freezes `count` and the prescaler phase. `pause` has no effect when the timer is not running.
- R6: `resume` while paused restarts counting from the held count without reloading, and keeps the held prescaler phase. `resume` has no effect unless the timer is paused.
- R7: `stop` makes the timer idle and sets `count` to 0 on the next edge. A later `resume` leaves `count` at 0.
- R8: A tick that arrives while `count` is 1 or 0 is an expiry. With `repeat_en` low, an expiry leaves `count` at 0 and the timer idle until the next `start`.
- R9: With `repeat_en` high, an expiry reloads `init_val` and counting continues at the same rate.
- R10: An expiry sets `flag` on the same edge. `flag` then stays set until a `flag_clr` cycle. If `flag_clr` and an expiry fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when `flag` is set and `irq_en` is high.
- R12: When several strobes arrive in the same cycle, `stop` beats `start`, `start` beats `pause`, and `pause` beats `resume`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_ce | input | 1 | Base-rate clock enable, one cycle per pulse |
| rate_sel | input | 2 | Tick rate code (0 is fastest, 3 is slowest) |
| init_val | input | CNT_W | Initial or reload value |
| repeat_en | input | 1 | Reload on expiry when high |
| start | input | 1 | Load and run strobe |
| pause | input | 1 | Freeze strobe |
| resume | input | 1 | Continue-from-pause strobe |
| stop | input | 1 | Disable-and-clear strobe |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Flag clear strobe (status read) |
| count | output | CNT_W | Live count value |
| flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Gated interrupt |

## Verification
The bench builds the timer with `PRE_DIV` = 2 and leaves the count at its default 16-bit width. With that setting a full period at the slowest rate, 128 base pulses, fits inside a short run, so all four rate codes can be timed edge by edge. The bench also drives the base enable both on every cycle and on every third cycle. This shows that the divider counts enable pulses rather than clock cycles. The short periods also let the bench line up a repeat-mode expiry with a held flag clear, and a strobe with a tick in the same cycle.

// File: rtl/pct_pkg.sv
// Shared types for the prescaled countdown timer.
// Assumes: nothing beyond standard SystemVerilog.
package pct_pkg;

    // Run state of the countdown controller
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

endpackage

// File: rtl/pct_prescale.sv
// Rate divider: a mod-PRE_DIV first stage followed by a binary second stage.
// Rate k ticks once every PRE_DIV * 2^(k*STEP_LOG2) advance pulses, counted from clear.
// Assumes: PRE_DIV >= 2 and NUM_RATES >= 2. rate_sel is held steady during a run.
module pct_prescale #(
    parameter int PRE_DIV   = 32,
    parameter int NUM_RATES = 4,
    parameter int STEP_LOG2 = 2,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int P1_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int P2_W = STEP_LOG2 * (NUM_RATES - 1);

    logic [P1_W-1:0]      p1_q;
    logic [P2_W-1:0]      p2_q;
    logic                 p1_wrap;
    logic [NUM_RATES-1:0] rate_tick;

    assign p1_wrap = advance_i && (p1_q == P1_W'(PRE_DIV - 1));

    // One tick line per rate; slower rates also need the low second-stage bits all ones
    generate
        for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
            if (k == 0) begin : g_fast
                assign rate_tick[k] = p1_wrap;
            end else begin : g_slow
                assign rate_tick[k] = p1_wrap && (&p2_q[k*STEP_LOG2-1:0]);
            end
        end
    endgenerate

    assign tick_o = (32'(sel_i) < NUM_RATES) ? rate_tick[sel_i] : 1'b0;

    // First stage: count advance pulses modulo PRE_DIV
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)  p1_q <= '0;
        else if (p1_wrap)       p1_q <= '0;
        else if (advance_i)     p1_q <= p1_q + P1_W'(1);
    end

    // Second stage: count first-stage wraps
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)  p2_q <= '0;
        else if (p1_wrap)       p2_q <= p2_q + P2_W'(1);
    end

    // R5
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> advance_i);

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !clear_i) |=> ($stable(p1_q) && $stable(p2_q)));

endmodule

// File: rtl/pct_ctrl.sv
// Countdown controller: run/hold/idle state, the counter, and expiry detection.
// Strobe priority is stop, then start, then pause, then resume.
// Assumes: tick_i is only high while running and no strobe is active.
module pct_ctrl
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             pause_i,
    input  logic             resume_i,
    input  logic             tick_i,
    input  logic             repeat_i,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             running_o,
    output logic             expire_o
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    // Next state and count, by strobe priority
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (stop_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (start_i) begin
            state_d = ST_RUN;
            cnt_d   = init_i;
        end else if (pause_i) begin
            if (state_q == ST_RUN) state_d = ST_HOLD;
        end else if (resume_i && state_q == ST_HOLD) begin
            state_d = ST_RUN;
        end else if (state_q == ST_RUN && tick_i) begin
            if (cnt_q <= CNT_W'(1)) begin
                expire = 1'b1;
                if (repeat_i) begin
                    cnt_d = init_i;
                end else begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end
    end

    // State and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign running_o = (state_q == ST_RUN);
    assign expire_o  = expire;

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (cnt_q == '0 && state_q == ST_IDLE));

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (cnt_q == $past(init_i) && state_q == ST_RUN));

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && !start_i && !stop_i && !pause_i && cnt_q > CNT_W'(1))
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !start_i && !stop_i) |=> $stable(cnt_q));

    // R8
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !repeat_i) |=> (cnt_q == '0 && state_q == ST_IDLE));

endmodule

// File: rtl/pct_flag.sv
// Sticky expiry flag with a clear strobe, plus interrupt gating.
// Assumes: expire_i is a single-cycle pulse; a set in the same cycle as a clear wins.
module pct_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Flag register: set on expiry, cleared by the status-read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (expire_i) flag_q <= 1'b1;
        else if (clr_i)    flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q);

    // R10
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> !flag_q);

endmodule

// File: rtl/pscl_countdown_timer.sv
// Prescaled countdown timer top: rate divider, countdown controller and expiry flag.
// Assumes: base_ce is a one-cycle enable at PRE_DIV * 1024 Hz for the nominal rates.
module pscl_countdown_timer #(
    parameter int CNT_W   = 16,
    parameter int PRE_DIV = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_ce,
    input  logic [1:0]       rate_sel,
    input  logic [CNT_W-1:0] init_val,
    input  logic             repeat_en,
    input  logic             start,
    input  logic             pause,
    input  logic             resume,
    input  logic             stop,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             irq
);
    localparam int NUM_RATES = 4;
    localparam int STEP_LOG2 = 2;

    logic running;
    logic advance;
    logic tick;
    logic expire;

    // The prescaler advances only while running and no strobe takes the cycle
    assign advance = base_ce && running && !start && !stop && !pause;

    pct_prescale #(
        .PRE_DIV   (PRE_DIV),
        .NUM_RATES (NUM_RATES),
        .STEP_LOG2 (STEP_LOG2),
        .SEL_W     (2)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start || stop),
        .advance_i (advance),
        .sel_i     (rate_sel),
        .tick_o    (tick)
    );

    pct_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .stop_i    (stop),
        .pause_i   (pause),
        .resume_i  (resume),
        .tick_i    (tick),
        .repeat_i  (repeat_en),
        .init_i    (init_val),
        .cnt_o     (count),
        .running_o (running),
        .expire_o  (expire)
    );

    pct_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (flag_clr),
        .irq_en_i (irq_en),
        .flag_o   (flag),
        .irq_o    (irq)
    );

endmodule

// File: tb/pscl_countdown_timer_tb_top.sv
// Bench: a behavioural model is compared on every clock, and directed checks cover the corner cases.
module pscl_countdown_timer_tb_top;
    localparam int CNT_W   = 16;
    localparam int PRE_DIV = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             base_ce = 1'b0;
    logic [1:0]       rate_sel = 2'd0;
    logic [CNT_W-1:0] init_val = '0;
    logic             repeat_en = 1'b0;
    logic             start = 1'b0, pause = 1'b0, resume = 1'b0, stop = 1'b0;
    logic             irq_en = 1'b0, flag_clr = 1'b0;
    logic [CNT_W-1:0] count;
    logic             flag, irq;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    int    ce_mode = 0;
    int    ce_ctr = 0;
    bit    chk_on = 0;
    string cur_req = "R1";

    // Reference model state
    int m_st = 0;   // 0 idle, 1 running, 2 paused
    int m_cnt = 0;
    int m_acc = 0;
    int m_flag = 0;

    always #4 clk = ~clk;

    pscl_countdown_timer #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_ce(base_ce), .rate_sel(rate_sel),
        .init_val(init_val), .repeat_en(repeat_en), .start(start), .pause(pause),
        .resume(resume), .stop(stop), .irq_en(irq_en), .flag_clr(flag_clr),
        .count(count), .flag(flag), .irq(irq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Base enable pattern: every cycle, or every third cycle
    always @(negedge clk) begin
        ce_ctr++;
        base_ce <= (ce_mode == 0) ? 1'b1 : ((ce_ctr % 3) == 0);
    end

    // Behavioural reference model, evaluated on each rising edge
    always @(posedge clk) begin
        bit expire_ev;
        int period;
        expire_ev = 0;
        period = PRE_DIV * (1 << (2 * rate_sel));
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_acc = 0; m_flag = 0;
        end else begin
            if (stop) begin
                m_st = 0; m_cnt = 0; m_acc = 0;
            end else if (start) begin
                m_st = 1; m_cnt = init_val; m_acc = 0;
            end else if (pause) begin
                if (m_st == 1) m_st = 2;
            end else if (resume && m_st == 2) begin
                m_st = 1;
            end else if (m_st == 1 && base_ce) begin
                m_acc++;
                if (m_acc == period) begin
                    m_acc = 0;
                    if (m_cnt <= 1) begin
                        expire_ev = 1;
                        if (repeat_en) m_cnt = init_val;
                        else begin m_cnt = 0; m_st = 0; end
                    end else begin
                        m_cnt--;
                    end
                end
            end
            if (expire_ev) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    // Compare every cycle, shortly after the edge
    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            check(cur_req, "count", int'(count), m_cnt);
            check(cur_req, "flag", int'(flag), m_flag);
            check("R11", "irq", int'(irq), (m_flag != 0 && irq_en) ? 1 : 0);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_start;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_pause;
        @(negedge clk); pause = 1'b1;
        @(negedge clk); pause = 1'b0;
    endtask

    task automatic do_resume;
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
    endtask

    task automatic do_stop;
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic do_clr;
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int held;
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1;

        // R1 reset state
        check("R1", "count", int'(count), 0);
        check("R1", "flag", int'(flag), 0);
        check("R1", "irq", int'(irq), 0);

        // R3 / R4: load, then first decrement one period later
        cur_req = "R3";
        rate_sel = 2'd0; init_val = 16'd7;
        do_start();
        check("R3", "count after start", int'(count), 7);
        wait_cyc(1);
        check("R3", "count before first tick", int'(count), 7);
        wait_cyc(1);
        check("R4", "count after first tick", int'(count), 6);

        // R8 / R10 / R11: one-shot expiry
        cur_req = "R8";
        wait_cyc(20);
        check("R8", "count at end", int'(count), 0);
        check("R10", "flag after expiry", int'(flag), 1);
        check("R11", "irq masked", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R11", "irq enabled", int'(irq), 1);
        wait_cyc(10);
        check("R10", "flag held", int'(flag), 1);
        do_clr();
        check("R10", "flag cleared", int'(flag), 0);

        // R5 / R6: pause holds, resume continues without reload
        cur_req = "R5";
        rate_sel = 2'd2; init_val = 16'd4;
        do_start();
        wait_cyc(40);
        do_pause();
        held = int'(count);
        check("R5", "count before hold", held, 3);
        wait_cyc(100);
        check("R5", "count held", int'(count), held);
        cur_req = "R6";
        do_resume();
        wait_cyc(30);
        check("R6", "count after resume", int'(count), 2);

        // R7: stop clears and resume after stop does nothing
        cur_req = "R7";
        do_stop();
        check("R7", "count after stop", int'(count), 0);
        do_resume();
        wait_cyc(50);
        check("R7", "count after resume from idle", int'(count), 0);
        do_pause();
        check("R5", "pause while idle", int'(count), 0);

        // R12: priority between strobes
        cur_req = "R12";
        rate_sel = 2'd0; init_val = 16'd200;
        @(negedge clk); start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        check("R12", "stop beats start", int'(count), 0);
        @(negedge clk); start = 1'b1; pause = 1'b1;
        @(negedge clk); start = 1'b0; pause = 1'b0;
        check("R12", "start beats pause", int'(count), 200);
        wait_cyc(20);
        check("R12", "running after start+pause", (count < 16'd200) ? 1 : 0, 1);
        @(negedge clk); pause = 1'b1; resume = 1'b1;
        @(negedge clk); pause = 1'b0; resume = 1'b0;
        held = int'(count);
        wait_cyc(20);
        check("R12", "pause beats resume", int'(count), held);
        do_stop();

        // R9 / R10: repeat mode with clear held high, sparse base enable
        cur_req = "R9";
        ce_mode = 1;
        rate_sel = 2'd1; init_val = 16'd3; repeat_en = 1'b1;
        flag_clr = 1'b1;
        do_start();
        wait_cyc(400);
        check("R9", "still counting", ((count >= 16'd1) && (count <= 16'd3)) ? 1 : 0, 1);
        flag_clr = 1'b0;
        wait_cyc(150);
        check("R10", "flag set in repeat", int'(flag), 1);
        repeat_en = 1'b0;
        ce_mode = 0;
        do_stop();
        do_clr();

        // R2: slowest rate, 128 base pulses per tick
        cur_req = "R2";
        rate_sel = 2'd3; init_val = 16'd2;
        do_start();
        wait_cyc(120);
        check("R2", "count before slow tick", int'(count), 2);
        wait_cyc(20);
        check("R2", "count after slow tick", int'(count), 1);
        wait_cyc(140);
        check("R2", "slow expiry", int'(flag), 1);
        do_clr();

        // R8: zero initial value expires on the first tick
        cur_req = "R8";
        rate_sel = 2'd0; init_val = 16'd0;
        do_start();
        wait_cyc(5);
        check("R8", "zero init flag", int'(flag), 1);
        check("R8", "zero init count", int'(count), 0);

        wait_cyc(5);
        chk_on = 0;
        finish_run();
    end

endmodule